// File: doc/BRIEF.md
# Two-Way Set-Associative Line Cache

This block sits between a processor load/store port and a main-memory port whose data bus is as wide as one cache line. It takes a 30-bit physical byte address and splits it into a line offset, a set index and a tag. Each set holds two entries. Each entry carries an 8-byte line, its tag and its own valid bit. A read compares both tags of the indexed set at once. On a hit, the addressed 32-bit word comes back in the same cycle. On a miss, the whole aligned line is fetched in a single memory transaction and written into a victim way. The request is then answered from the cache on the following cycle.

The victim is the lowest-numbered empty way of the set. When both ways are occupied, the victim comes from a free-running pseudo-random register. Writes use the write-through policy. Every write goes to memory. A write that hits also updates the cached copy of the word. A write that misses leaves the cache untouched. A one-cycle invalidate pulse empties the whole cache. Software issues it on a context switch.

The processor holds `cpu_valid` and its request fields stable until it sees `cpu_ready`. The memory side holds `mem_req` and its fields stable until the single-cycle `mem_ack`, which carries the read line on `mem_rdata`.

Top module: `assoc_rd_cache`

## Requirements
- R1: Address bits [29:12] are the tag, bits [11:3] the set index and bits [2:0] the byte offset. Bit 2 picks the word: 0 returns line bits [31:0] (bytes 0..3) and 1 returns line bits [63:32] (bytes 4..7). Bits [1:0] are ignored. For example, 0x0001AC44 has tag 0x0001A, set 0x188 and returns bytes 4..7.
- R2: A read whose tag matches a valid way of the indexed set raises `cpu_ready` in the same cycle as `cpu_valid`, returns the addressed word on `cpu_rdata`, and does not raise `mem_req`.
- R3: A read that misses raises `mem_req` with `mem_we`=0 and `mem_addr` set to the address with bits [2:0] cleared. `cpu_ready` stays low up to and including the `mem_ack` cycle.
- R4: A read-miss `mem_ack` (without invalidate) stores the tag and the 64-bit `mem_rdata` in the victim way and sets its valid bit. The held request is then answered as a hit in the next cycle, and later reads of either word of that line also hit.
- R5: The victim is the lowest-numbered invalid way of the set. If both ways are valid, bit 0 of an 8-bit random register picks the way (0 selects way 0). The register resets to 0xA5 and steps on every clock after reset as r <= {r[6:0], r[7]^r[5]^r[4]^r[3]}. The victim uses the value present at the `mem_ack` edge.
- R6: Two different tags that share a set index can be resident at the same time, and both hit.
- R7: Reset clears every valid bit, so the first read of any address misses. During reset `cpu_ready` and `mem_req` are low.
- R8: `inval` high at a clock edge clears all valid bits at that edge. If it coincides with a read-miss `mem_ack`, the fill is dropped.
- R9: A write raises `mem_req` with `mem_we`=1, the line-aligned `mem_addr`, `mem_wdata` = {`cpu_wdata`,`cpu_wdata`} and `mem_wstrb` = 0xF0 when bit 2 is 1 or 0x0F when it is 0. `cpu_ready` rises in the `mem_ack` cycle.
- R10: On a write hit, the cached word is updated at the `mem_ack` edge. On a write miss, nothing is allocated, so a later read of that line misses.
- R11: With `cpu_valid` low, `cpu_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval | input | 1 | Empty the whole cache at this edge |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 30 | Physical byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 30 | Line-aligned memory address |
| mem_wdata | output | 64 | Write data, word replicated in both halves |
| mem_wstrb | output | 8 | Byte enables for a write |
| mem_ack | input | 1 | Memory transaction done this cycle |
| mem_rdata | input | 64 | Line read from memory, valid with `mem_ack` |

## Verification
Corrupted tag, data or valid state shows up at the ports on the first read of the affected set, and not before. A wrongly kept entry answers with `cpu_ready` in the request cycle where a fetch should start. A wrongly lost entry raises `mem_req` where an immediate hit was due. A stale line returns a wrong `cpu_rdata` word. A wrong victim choice surfaces only when the evicted tag is read again, so the bench mirrors the random register and the per-way state and compares every port on every clock. Long mixed runs over a few shared sets force evictions, invalidates that collide with fills, and write hits on lines that were just filled.

// File: rtl/arc_pkg.sv
package arc_pkg;

   // Feedback tap masks for a left-shifting register whose new LSB is the
   // XOR of the masked bits. Zero marks an unsupported width.
   function automatic logic [31:0] lfsr_taps(input int unsigned w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/arc_lfsr.sv
module arc_lfsr #(
   parameter int unsigned W    = 8,
   parameter logic [W-1:0] SEED = 8'hA5
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state_o
);
   localparam logic [31:0] TAPS_FULL = arc_pkg::lfsr_taps(W);
   localparam logic [W-1:0] TAPS     = TAPS_FULL[W-1:0];

   if (TAPS_FULL == 32'd0) begin : g_bad_width
      $error("arc_lfsr: unsupported width");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("arc_lfsr: seed must be nonzero");
   end

   logic [W-1:0] r_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= SEED;
      else        r_q <= {r_q[W-2:0], ^(r_q & TAPS)};
   end

   assign state_o = r_q;
endmodule

// File: rtl/arc_way.sv
module arc_way #(
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned TAG_W  = 18,
   parameter int unsigned LINE_W = 64,
   parameter int unsigned WORD_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_all,
   input  logic [IDX_W-1:0]           idx,
   output logic                       vld_o,
   output logic [TAG_W-1:0]           tag_o,
   output logic [LINE_W-1:0]          line_o,
   input  logic                       fill_en,
   input  logic [TAG_W-1:0]           fill_tag,
   input  logic [LINE_W-1:0]          fill_line,
   input  logic                       wr_en,
   input  logic [$clog2(LINE_W/WORD_W)-1:0] wsel,
   input  logic [WORD_W-1:0]          wdata
);
   localparam int unsigned SETS = 1 << IDX_W;

   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [LINE_W-1:0] data_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q <= '0;
      else if (clr_all) valid_q <= '0;
      else if (fill_en) valid_q[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[idx]  <= fill_tag;
         data_q[idx] <= fill_line;
      end else if (wr_en) begin
         data_q[idx][wsel*WORD_W +: WORD_W] <= wdata;
      end
   end

   assign vld_o  = valid_q[idx];
   assign tag_o  = tag_q[idx];
   assign line_o = data_q[idx];
endmodule

// File: rtl/arc_victim.sv
module arc_victim #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned RND_W = 8
) (
   input  logic [WAYS-1:0]          vld,
   input  logic [RND_W-1:0]         rnd,
   output logic [$clog2(WAYS)-1:0]  way_o
);
   localparam int unsigned WAY_BITS = $clog2(WAYS);

   always_comb begin
      way_o = rnd[WAY_BITS-1:0];
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld[w]) way_o = WAY_BITS'(w);
      end
   end
endmodule

// File: rtl/assoc_rd_cache.sv
module assoc_rd_cache #(
   parameter int unsigned ADDR_W   = 30,
   parameter int unsigned TAG_W    = 18,
   parameter int unsigned IDX_W    = 9,
   parameter int unsigned OFS_W    = 3,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned WAYS     = 2,
   parameter int unsigned RND_W    = 8,
   parameter logic [RND_W-1:0] RND_SEED = 8'hA5,
   localparam int unsigned LINE_BYTES = 1 << OFS_W,
   localparam int unsigned LINE_W     = 8 * LINE_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inval,
   input  logic                  cpu_valid,
   input  logic                  cpu_we,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic [WORD_W-1:0]     cpu_wdata,
   output logic                  cpu_ready,
   output logic [WORD_W-1:0]     cpu_rdata,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [LINE_W-1:0]     mem_wdata,
   output logic [LINE_BYTES-1:0] mem_wstrb,
   input  logic                  mem_ack,
   input  logic [LINE_W-1:0]     mem_rdata
);
   localparam int unsigned WORD_BYTES = WORD_W / 8;
   localparam int unsigned WB_LOG     = $clog2(WORD_BYTES);
   localparam int unsigned WSEL_W     = OFS_W - WB_LOG;
   localparam int unsigned WPL        = 1 << WSEL_W;
   localparam int unsigned WAY_BITS   = $clog2(WAYS);

   // ---------------- elaboration checks ----------------
   if (TAG_W + IDX_W + OFS_W != ADDR_W) begin : g_bad_split
      $error("assoc_rd_cache: tag, index and offset must fill the address");
   end
   if ((WORD_W % 8) != 0 || !arc_pkg::is_pow2(WORD_BYTES)) begin : g_bad_word
      $error("assoc_rd_cache: word must be a power-of-two number of bytes");
   end
   if (WORD_BYTES >= LINE_BYTES) begin : g_bad_line
      $error("assoc_rd_cache: a line must hold at least two words");
   end
   if (WAYS < 2 || !arc_pkg::is_pow2(WAYS)) begin : g_bad_ways
      $error("assoc_rd_cache: way count must be a power of two, at least 2");
   end
   if (RND_W < WAY_BITS) begin : g_bad_rnd
      $error("assoc_rd_cache: random source narrower than way select");
   end

   // ---------------- address fields ----------------
   logic [TAG_W-1:0]  tag_f;
   logic [IDX_W-1:0]  idx_f;
   logic [WSEL_W-1:0] wsel_f;
   logic              unused_lo;

   assign tag_f     = cpu_addr[ADDR_W-1 -: TAG_W];
   assign idx_f     = cpu_addr[OFS_W +: IDX_W];
   assign wsel_f    = cpu_addr[WB_LOG +: WSEL_W];
   assign unused_lo = ^cpu_addr[WB_LOG-1:0];

   // ---------------- request decode ----------------
   logic rd_req, wr_req, hit, fill, word_wr;
   logic [WAYS-1:0]     way_vld, hit_vec, fill_vec;
   logic [TAG_W-1:0]    way_tag  [WAYS];
   logic [LINE_W-1:0]   way_line [WAYS];
   logic [LINE_W-1:0]   hit_line;
   logic [RND_W-1:0]    rnd_q;
   logic [WAY_BITS-1:0] victim;

   assign rd_req  = cpu_valid && !cpu_we;
   assign wr_req  = cpu_valid &&  cpu_we;
   assign fill    = rd_req && !hit && mem_ack && !inval;
   assign word_wr = wr_req && mem_ack;

   // ---------------- ways ----------------
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      arc_way #(
         .IDX_W (IDX_W),
         .TAG_W (TAG_W),
         .LINE_W(LINE_W),
         .WORD_W(WORD_W)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_all  (inval),
         .idx      (idx_f),
         .vld_o    (way_vld[w]),
         .tag_o    (way_tag[w]),
         .line_o   (way_line[w]),
         .fill_en  (fill_vec[w]),
         .fill_tag (tag_f),
         .fill_line(mem_rdata),
         .wr_en    (word_wr && hit_vec[w]),
         .wsel     (wsel_f),
         .wdata    (cpu_wdata)
      );

      assign hit_vec[w]  = way_vld[w] && (way_tag[w] == tag_f);
      assign fill_vec[w] = fill && (victim == WAY_BITS'(w));
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_line = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_line = hit_line | way_line[w];
      end
   end

   // ---------------- replacement ----------------
   arc_lfsr #(
      .W   (RND_W),
      .SEED(RND_SEED)
   ) u_rnd (
      .clk    (clk),
      .rst_n  (rst_n),
      .state_o(rnd_q)
   );

   arc_victim #(
      .WAYS (WAYS),
      .RND_W(RND_W)
   ) u_victim (
      .vld  (way_vld),
      .rnd  (rnd_q),
      .way_o(victim)
   );

   // ---------------- outputs ----------------
   assign cpu_ready = (rd_req && hit) || (wr_req && mem_ack);
   assign cpu_rdata = hit_line[wsel_f*WORD_W +: WORD_W];

   assign mem_req   = wr_req || (rd_req && !hit);
   assign mem_we    = wr_req;
   assign mem_addr  = {cpu_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
   assign mem_wdata = {WPL{cpu_wdata}};
   assign mem_wstrb = {{(LINE_BYTES-WORD_BYTES){1'b0}}, {WORD_BYTES{1'b1}}}
                      << (WORD_BYTES * wsel_f);
endmodule

// File: rtl/arc_chk.sv
module arc_chk #(
   parameter int unsigned ADDR_W = 30,
   parameter int unsigned OFS_W  = 3,
   parameter int unsigned RND_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inval,
   input logic              cpu_valid,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic [RND_W-1:0]  rnd
);
   AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_valid); // R11
   AST_MEMREQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_valid); // R11
   AST_HIT_NO_MEMREQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_we && cpu_ready) |-> !mem_req); // R2
   AST_WRITE_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_we && cpu_ready) |-> mem_ack); // R9
   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFS_W-1:0] == '0)); // R3
   AST_MISS_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_we && mem_req) |-> !cpu_ready); // R3
   AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_we && mem_req && mem_ack && !inval)
      |=> (!cpu_valid || cpu_we || !$stable(cpu_addr) || cpu_ready)); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> !(cpu_valid && !cpu_we && cpu_ready)); // R8
   AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rnd != '0); // R5
endmodule

bind assoc_rd_cache arc_chk #(
   .ADDR_W(ADDR_W),
   .OFS_W (OFS_W),
   .RND_W (RND_W)
) u_arc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .inval    (inval),
   .cpu_valid(cpu_valid),
   .cpu_we   (cpu_we),
   .cpu_addr (cpu_addr),
   .cpu_ready(cpu_ready),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .mem_ack  (mem_ack),
   .rnd      (rnd_q)
);

// File: tb/tb_assoc_rd_cache.sv
`timescale 1ns/1ps
module tb_assoc_rd_cache;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inval = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_we = 1'b0;
   logic [29:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [29:0] mem_addr;
   logic [63:0] mem_wdata;
   logic [7:0]  mem_wstrb;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   bit rnd_inval = 0;

   always #5 clk = ~clk;

   assoc_rd_cache dut (
      .clk(clk), .rst_n(rst_n), .inval(inval),
      .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // ---------------- reference model ----------------
   bit [31:0] wmem [bit [27:0]];
   bit        mv   [512][2];
   bit [17:0] mtag [512][2];
   bit [63:0] mdat [512][2];
   bit [7:0]  mrnd = 8'hA5;
   int        last_victim = -1;
   int        mcnt = 0;

   function automatic bit [31:0] mword(bit [27:0] wa);
      if (wmem.exists(wa)) return wmem[wa];
      return {wa[15:0], ~wa[15:0]} ^ {4'hA, wa};
   endfunction

   function automatic bit [63:0] mline(bit [29:0] a);
      return {mword({a[29:3], 1'b1}), mword({a[29:3], 1'b0})};
   endfunction

   function automatic int mfind(bit [29:0] a);
      for (int w = 0; w < 2; w++)
         if (mv[a[11:3]][w] && mtag[a[11:3]][w] == a[29:12]) return w;
      return -1;
   endfunction

   task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // memory responder and model state update
   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (mv[s, w]) mv[s][w] = 0;
         mrnd = 8'hA5;
         mcnt = 0;
         mem_ack <= 1'b0;
      end else begin
         int hw;
         hw = mfind(cpu_addr);
         if (cpu_valid && cpu_we && mem_ack) begin
            wmem[cpu_addr[29:2]] = cpu_wdata;
            if (hw >= 0) begin
               if (cpu_addr[2]) mdat[cpu_addr[11:3]][hw][63:32] = cpu_wdata;
               else             mdat[cpu_addr[11:3]][hw][31:0]  = cpu_wdata;
            end
         end
         if (cpu_valid && !cpu_we && hw < 0 && mem_ack && !inval) begin
            int v;
            if (!mv[cpu_addr[11:3]][0])      v = 0;
            else if (!mv[cpu_addr[11:3]][1]) v = 1;
            else                             v = int'(mrnd[0]);
            last_victim = v;
            mv[cpu_addr[11:3]][v]   = 1;
            mtag[cpu_addr[11:3]][v] = cpu_addr[29:12];
            mdat[cpu_addr[11:3]][v] = mline(cpu_addr);
         end
         if (inval) foreach (mv[s, w]) mv[s][w] = 0;
         mrnd = {mrnd[6:0], mrnd[7] ^ mrnd[5] ^ mrnd[4] ^ mrnd[3]};
         // memory side: ack LAT cycles after the request appears
         if (mem_req && !mem_ack) begin
            if (mcnt == LAT - 1) begin
               mem_ack   <= 1'b1;
               mem_rdata <= mline(mem_addr);
               mcnt = 0;
            end else mcnt++;
         end else mem_ack <= 1'b0;
      end
   end

   // cycle-by-cycle port comparison
   always @(negedge clk) begin
      if (rst_n) begin
         int hw;
         bit er, eq;
         string rq;
         hw = mfind(cpu_addr);
         er = cpu_valid && (cpu_we ? mem_ack : (hw >= 0));
         eq = cpu_valid && (cpu_we || hw < 0);
         rq = !cpu_valid ? "R11" : cpu_we ? "R9" : (hw >= 0) ? "R2" : "R3";
         chk(rq, "cpu_ready/mem_req", {62'd0, cpu_ready, mem_req}, {62'd0, er, eq});
         if (eq) begin
            chk(rq, "mem_we/mem_addr", {33'd0, mem_we, mem_addr},
                {33'd0, cpu_we, cpu_addr[29:3], 3'b000});
            if (cpu_we) begin
               chk("R9", "mem_wdata", mem_wdata, {cpu_wdata, cpu_wdata});
               chk("R9", "mem_wstrb", {56'd0, mem_wstrb},
                   {56'd0, cpu_addr[2] ? 8'hF0 : 8'h0F});
            end
         end
         if (er && !cpu_we && hw >= 0)
            chk("R1", "cpu_rdata", {32'd0, cpu_rdata},
                {32'd0, cpu_addr[2] ? mdat[cpu_addr[11:3]][hw][63:32]
                                    : mdat[cpu_addr[11:3]][hw][31:0]});
      end
   end

   // ---------------- stimulus ----------------
   task automatic xfer(input bit we, input bit [29:0] a, input bit [31:0] d,
                       output bit [31:0] q, output int lat);
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; lat = 0;
      forever begin
         @(negedge clk);
         if (cpu_ready) break;
         lat++;
         @(posedge clk); #1;
         inval = rnd_inval && ($urandom_range(0, 15) == 0);
      end
      q = cpu_rdata;
      @(posedge clk); #1;
      cpu_valid = 1'b0; inval = 1'b0;
   endtask

   task automatic pulse_inval();
      inval = 1'b1;
      @(posedge clk); #1;
      inval = 1'b0;
   endtask

   initial begin
      fork
         begin : watchdog
            repeat (150000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
         end
      join_none
   end

   initial begin
      bit [31:0] q;
      int lat;
      bit [29:0] a_a, a_b, a_c;
      int vic;

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7", "ready in reset", {63'd0, cpu_ready}, 64'd0);
      chk("R11", "mem_req in reset", {63'd0, mem_req}, 64'd0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 / R7: the example address misses first, then returns bytes 4..7
      a_a = 30'h0001AC44;
      xfer(0, a_a, 0, q, lat);
      chk("R7", "first read misses", 64'(lat > 0), 64'd1);
      chk("R1", "0x0001AC44 word", {32'd0, q}, {32'd0, mword(28'h0006B11)});
      xfer(0, 30'h0001AC47, 0, q, lat);
      chk("R1", "low bits ignored", {32'd0, q}, {32'd0, mword(28'h0006B11)});
      chk("R2", "hit latency", 64'(lat), 64'd0);
      xfer(0, 30'h0001AC40, 0, q, lat);
      chk("R4", "other word of filled line", {32'd0, q}, {32'd0, mword(28'h0006B10)});
      chk("R4", "other word hits", 64'(lat), 64'd0);

      // R6: second tag in set 0x188
      a_b = 30'h0002AC44;
      xfer(0, a_b, 0, q, lat);
      chk("R3", "second tag misses", 64'(lat > 0), 64'd1);
      xfer(0, a_a, 0, q, lat);
      chk("R6", "first tag still hits", 64'(lat), 64'd0);
      xfer(0, a_b, 0, q, lat);
      chk("R6", "second tag hits", 64'(lat), 64'd0);

      // R5: third tag forces a random eviction
      a_c = 30'h0003AC40;
      xfer(0, a_c, 0, q, lat);
      vic = last_victim;
      xfer(0, a_c, 0, q, lat);
      chk("R4", "third tag hits after fill", 64'(lat), 64'd0);
      xfer(0, a_a, 0, q, lat);
      chk("R5", "way 0 survives iff way 1 evicted", 64'(lat == 0), 64'(vic == 1));

      // R9 / R10: write hit updates cache and memory
      xfer(0, a_c, 0, q, lat);
      xfer(1, a_c, 32'hDEAD_BEEF, q, lat);
      chk("R9", "write completes on ack", 64'(lat), 64'(LAT));
      xfer(0, a_c, 0, q, lat);
      chk("R10", "write hit updated cache", {32'd0, q}, 64'hDEAD_BEEF);
      chk("R10", "read after write hits", 64'(lat), 64'd0);

      // R8: invalidate empties everything
      pulse_inval();
      xfer(0, a_c, 0, q, lat);
      chk("R8", "miss after invalidate", 64'(lat > 0), 64'd1);
      chk("R9", "memory holds written word", {32'd0, q}, 64'hDEAD_BEEF);

      // R10: write miss does not allocate
      xfer(1, 30'h00400004, 32'h1234_5678, q, lat);
      xfer(0, 30'h00400004, 0, q, lat);
      chk("R10", "write miss not allocated", 64'(lat > 0), 64'd1);
      chk("R10", "read returns written word", {32'd0, q}, 64'h1234_5678);

      // mixed run: evictions, invalidates colliding with fills
      rnd_inval = 1;
      for (int i = 0; i < 1500; i++) begin
         bit [29:0] a;
         bit [8:0] st;
         case ($urandom_range(0, 2))
            0: st = 9'h188;
            1: st = 9'h000;
            default: st = 9'h1FF;
         endcase
         a = {18'($urandom_range(1, 5)), st, 3'($urandom)};
         xfer($urandom_range(0, 3) == 0, a, $urandom, q, lat);
         if ($urandom_range(0, 3) == 0) begin
            @(posedge clk); #1;
         end
      end
      rnd_inval = 0;

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule